// File: doc/BRIEF.md
# Bitslip Word Aligner with Deserializer

This block takes a serial bitstream clocked by a fast bit clock and converts it into parallel words of `WORD_W` bits. Before the bits reach the deserializer, they pass through a delay line whose length is set in whole bit periods. Word-alignment logic outside the block searches the parallel output for a known control character. Each time the search fails, that logic pulses the slip request. Every pulse moves the word boundary by one bit.

A rising edge on `slip_req` is brought into the bit-clock domain through a synchronizer and an edge detector, so each request adds one bit of delay no matter how long it is held. The delay counter runs from zero up to `ROLL_CNT-1` and then wraps back to zero. `slip_max` warns that the next request will cause that wrap. `ROLL_CNT` is meant to be at least `WORD_W`, so that the boundary can be walked through every bit position of a word. An asynchronous `slip_rst` returns the delay to zero at any time. The parallel word register changes only on cycles where `load_en` is high; `load_en` is a pulse once every `WORD_W` bit clocks.

Top module: `bsa_word_aligner`

## Requirements
- R1: While reset is active, and on release of reset, `par_out` is all zeros and `slip_max` is low.
- R2: With zero slip delay, a word loaded at the bit-clock edge where `load_en` is sampled high holds the `WORD_W` bits sampled on `ser_in` at the previous `WORD_W` edges. The oldest of those bits is in the MSB (bit `WORD_W-1`) and the newest is in bit 0.
- R3: Each slip adds one bit period of delay. With delay d, the loaded word holds the bits sampled d edges earlier than in R2.
- R4: A slip request held high for several bit clocks adds exactly one bit of delay.
- R5: A slip at delay `ROLL_CNT-1` returns the delay to zero.
- R6: `slip_max` is high exactly when the delay is `ROLL_CNT-1`. It is valid no later than five `load_en` periods after a slip request.
- R7: Raising `slip_rst` clears `slip_max` at once, without waiting for a clock edge. After release, the data path runs with zero delay.
- R8: `par_out` changes only at edges where `load_en` is high, and holds its value between those edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| slip_rst | input | 1 | Asynchronous active-high clear of the slip delay |
| load_en | input | 1 | Word load strobe, one cycle in every `WORD_W` |
| ser_in | input | 1 | Serial data in |
| slip_req | input | 1 | Slip request; each rising edge adds one bit of delay |
| par_out | output | WORD_W | Deserialized word, MSB is the first bit received |
| slip_max | output | 1 | High when the next slip wraps the delay to zero |

## Verification
The case that is hardest to reach from the ports is the rollover point. To get there, the stimulus issues single-cycle slip requests one at a time, letting the data settle and checking it after each one, until the delay reaches `ROLL_CNT-1`. It then confirms that the flag is high and issues one more request to check the wrap. The clear is tested in a second way: starting from that same maximum state, the bench raises `slip_rst` between clock edges and samples `slip_max` before any edge arrives, which shows that the clear does not wait for the clock. A request held high for six cycles is also applied, and the following data shows whether it was counted more than once.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

  // Width of a counter that holds the values 0 .. n-1.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/bsa_edge_sync.sv
module bsa_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_pulse
);

  // Synchronizer stages plus one history flop for edge detection.
  logic [SYNC_STAGES:0] stage_q;
  logic [SYNC_STAGES:0] stage_d;

  always_comb begin
    stage_d[0] = async_in;
    for (int i = 1; i <= SYNC_STAGES; i++) begin
      stage_d[i] = stage_q[i-1];
    end
  end

  genvar g;
  generate
    for (g = 0; g <= SYNC_STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= 1'b0;
        else        stage_q[g] <= stage_d[g];
      end
    end
  endgenerate

  assign rise_pulse = stage_q[SYNC_STAGES-1] & ~stage_q[SYNC_STAGES];

endmodule

// File: rtl/bsa_slip_ctr.sv
module bsa_slip_ctr #(
  parameter int unsigned ROLL_CNT = 10,
  parameter int unsigned CNT_W    = bsa_pkg::cnt_width(ROLL_CNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slip_clr,
  input  logic             slip_pulse,
  output logic [CNT_W-1:0] cnt_o,
  output logic             max_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(ROLL_CNT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             max_q, max_d;

  always_comb begin
    cnt_d = cnt_q;
    if (slip_pulse) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
    max_d = (cnt_q == LAST);
  end

  always_ff @(posedge clk or negedge rst_n or posedge slip_clr) begin
    if (!rst_n) begin
      cnt_q <= '0;
      max_q <= 1'b0;
    end else if (slip_clr) begin
      cnt_q <= '0;
      max_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      max_q <= max_d;
    end
  end

  assign cnt_o = cnt_q;
  assign max_o = max_q;

endmodule

// File: rtl/bsa_delay_line.sv
module bsa_delay_line #(
  parameter int unsigned DEPTH = 10,
  parameter int unsigned SEL_W = bsa_pkg::cnt_width(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_in,
  input  logic [SEL_W-1:0] tap_sel,
  output logic             bit_out
);

  logic [DEPTH-1:0] line_q, line_d;

  always_comb begin
    line_d = {line_q[DEPTH-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_d;
  end

  // Tap 0 is one bit period behind the input; each step adds one more.
  assign bit_out = line_q[tap_sel];

endmodule

// File: rtl/bsa_deser.sv
module bsa_deser #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_in,
  input  logic              load_en,
  output logic [WORD_W-1:0] word_o
);

  logic [WORD_W-2:0] shift_q, shift_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [WORD_W-1:0] assembled;

  always_comb begin
    assembled = {shift_q, bit_in};
    shift_d   = assembled[WORD_W-2:0];
    word_d    = load_en ? assembled : word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      word_q  <= '0;
    end else begin
      shift_q <= shift_d;
      word_q  <= word_d;
    end
  end

  assign word_o = word_q;

endmodule

// File: rtl/bsa_word_aligner.sv
module bsa_word_aligner #(
  parameter int unsigned WORD_W      = 8,
  parameter int unsigned ROLL_CNT    = 10,  // keep at or above WORD_W
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slip_rst,
  input  logic              load_en,
  input  logic              ser_in,
  input  logic              slip_req,
  output logic [WORD_W-1:0] par_out,
  output logic              slip_max
);

  localparam int unsigned CNT_W = bsa_pkg::cnt_width(ROLL_CNT);

  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  logic             slip_pulse;
  logic [CNT_W-1:0] slip_cnt;
  logic             delayed_bit;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  bsa_edge_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_edge (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .async_in  (slip_req),
    .rise_pulse(slip_pulse)
  );

  bsa_slip_ctr #(
    .ROLL_CNT(ROLL_CNT),
    .CNT_W   (CNT_W)
  ) u_ctr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .slip_clr  (slip_rst),
    .slip_pulse(slip_pulse),
    .cnt_o     (slip_cnt),
    .max_o     (slip_max)
  );

  bsa_delay_line #(
    .DEPTH(ROLL_CNT),
    .SEL_W(CNT_W)
  ) u_dly (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .bit_in (ser_in),
    .tap_sel(slip_cnt),
    .bit_out(delayed_bit)
  );

  bsa_deser #(
    .WORD_W(WORD_W)
  ) u_deser (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .bit_in (delayed_bit),
    .load_en(load_en),
    .word_o (par_out)
  );

endmodule

// File: rtl/bsa_word_aligner_chk.sv
module bsa_word_aligner_chk #(
  parameter int unsigned WORD_W   = 8,
  parameter int unsigned ROLL_CNT = 10,
  parameter int unsigned CNT_W    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slip_rst,
  input logic              load_en,
  input logic              slip_pulse,
  input logic [CNT_W-1:0]  cnt,
  input logic              slip_max,
  input logic [WORD_W-1:0] par_out
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(ROLL_CNT - 1);

  assert_slip_step_R3: assert property (@(posedge clk) disable iff (!rst_n || slip_rst)
    (slip_pulse && cnt != LAST) |=> (cnt == $past(cnt) + 1'b1));

  assert_no_drift_R3: assert property (@(posedge clk) disable iff (!rst_n || slip_rst)
    !slip_pulse |=> $stable(cnt));

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    slip_pulse |=> !slip_pulse);

  assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n || slip_rst)
    (slip_pulse && cnt == LAST) |=> (cnt == '0));

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n || slip_rst)
    (cnt == LAST) |=> slip_max);

  assert_flag_clr_R6: assert property (@(posedge clk) disable iff (!rst_n || slip_rst)
    (cnt != LAST) |=> !slip_max);

  assert_word_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(par_out));

endmodule

bind bsa_word_aligner bsa_word_aligner_chk #(
  .WORD_W  (WORD_W),
  .ROLL_CNT(ROLL_CNT),
  .CNT_W   (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .slip_rst  (slip_rst),
  .load_en   (load_en),
  .slip_pulse(slip_pulse),
  .cnt       (slip_cnt),
  .slip_max  (slip_max),
  .par_out   (par_out)
);

// File: tb/test_bsa_word_aligner.sv
module test_bsa_word_aligner;

  localparam int WW   = 8;
  localparam int ROLL = 10;

  logic          clk = 1'b0;
  logic          rst_n, slip_rst, load_en, ser_in, slip_req;
  logic [WW-1:0] par_out;
  logic          slip_max;

  int            n_chk = 0;
  int            n_err = 0;
  int            n;
  int            exp_d;
  logic          last_le;
  logic [15:0]   lfsr;
  logic          hist [0:16383];
  bit            done = 0;

  always #4 clk = ~clk;

  bsa_word_aligner #(.WORD_W(WW), .ROLL_CNT(ROLL), .SYNC_STAGES(2)) i_bsa_word_aligner (
    .clk(clk), .rst_n(rst_n), .slip_rst(slip_rst), .load_en(load_en),
    .ser_in(ser_in), .slip_req(slip_req), .par_out(par_out), .slip_max(slip_max)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic gen_bit(input int pat, output logic b);
    case (pat)
      0: begin
        b = lfsr[0];
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      end
      1: b = ((n + 1) % 3 == 0);
      default: b = ((n + 1) % 11 != 5);
    endcase
  endtask

  // Drive one bit period from a falling edge to the next falling edge.
  task automatic step(input logic b, input logic sr);
    ser_in   = b;
    slip_req = sr;
    load_en  = ((n + 1) % WW == 0);
    @(posedge clk);
    n++;
    hist[n] = b;
    last_le = load_en;
    @(negedge clk);
  endtask

  task automatic run_words(input int nw, input int pat, input string req);
    logic [WW-1:0] exp_w;
    logic          b;
    int            words = 0;
    bit            have = 0;
    for (int c = 0; c < nw * WW; c++) begin
      gen_bit(pat, b);
      step(b, 1'b0);
      if (last_le) begin
        words++;
        for (int i = 0; i < WW; i++) exp_w[WW-1-i] = hist[n - WW - exp_d + i];
        if (words > 2) begin
          check(par_out == exp_w, req, 32'(par_out), 32'(exp_w));
          have = 1;
        end
      end else if (have) begin
        check(par_out == exp_w, "R8", 32'(par_out), 32'(exp_w));
      end
    end
  endtask

  task automatic slip_once(input int width);
    logic b;
    for (int i = 0; i < width; i++) begin gen_bit(0, b); step(b, 1'b1); end
    for (int i = 0; i < 4; i++) begin gen_bit(0, b); step(b, 1'b0); end
    exp_d = (exp_d + 1) % ROLL;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; slip_rst = 1'b0; load_en = 1'b0; ser_in = 1'b0; slip_req = 1'b0;
    repeat (3) @(negedge clk);
    check(par_out == '0, "R1", 32'(par_out), 0);
    check(slip_max == 1'b0, "R1", 32'(slip_max), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(par_out == '0, "R1", 32'(par_out), 0);
    check(slip_max == 1'b0, "R1", 32'(slip_max), 0);
    n = 0; exp_d = 0;
  endtask

  task automatic t_plain();
    run_words(6, 0, "R2");
    run_words(5, 1, "R2");
    run_words(5, 2, "R2");
  endtask

  task automatic t_single_slips();
    for (int k = 0; k < 3; k++) begin
      slip_once(1);
      run_words(6, 0, "R3");
      check(slip_max == 1'b0, "R6", 32'(slip_max), 0);
    end
  endtask

  task automatic t_wide_slip();
    slip_once(6);
    run_words(6, 2, "R4");
  endtask

  task automatic t_walk_to_max();
    while (exp_d != ROLL - 1) begin
      slip_once(1);
      run_words(3, 0, "R3");
    end
    run_words(5, 0, "R6");
    check(slip_max == 1'b1, "R6", 32'(slip_max), 1);
    slip_once(1);
    run_words(6, 0, "R5");
    check(slip_max == 1'b0, "R5", 32'(slip_max), 0);
  endtask

  task automatic t_async_clear();
    logic b;
    while (exp_d != ROLL - 1) slip_once(1);
    run_words(6, 0, "R6");
    check(slip_max == 1'b1, "R6", 32'(slip_max), 1);
    #1 slip_rst = 1'b1;
    #1 check(slip_max == 1'b0, "R7", 32'(slip_max), 0);
    @(negedge clk);
    gen_bit(0, b); step(b, 1'b0);
    slip_rst = 1'b0;
    exp_d = 0;
    run_words(6, 0, "R7");
    check(slip_max == 1'b0, "R7", 32'(slip_max), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    lfsr = 16'hACE1;
    for (int i = 0; i < 16384; i++) hist[i] = 1'b0;
    @(negedge clk);
    t_reset();
    t_plain();
    t_single_slips();
    t_wide_slip();
    t_walk_to_max();
    t_async_clear();
    finish_run();
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

endmodule